// File: doc/BRIEF.md
# Internal Bus Timeout Monitor

This block watches a processor-internal request/acknowledge bus and makes sure that every transfer ends. Each request aimed at an internal slave starts a window of a fixed number of clock cycles. The window closes when the slave acknowledges or flags an error. If neither happens in time, the monitor raises a bus error toward the CPU. A typical cause is an access to an address hole where no slave answers. The monitor also passes on error responses that come from slaves.

Each reported error carries a type bit. The bit tells whether the failing transfer was an instruction fetch or a data access, so the CPU can raise the matching fault. Requests marked as going to the external memory region are not tracked at all, because that path has its own timeout handling. The window length is a build-time parameter with a default of 15 cycles.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset, `err_o` and `err_fetch_o` are 0. Without a tracked request, `err_o` stays 0.
- R2: A request with `ext_i`=1 is not tracked. No error follows it, even when no acknowledge arrives or when `serr_i` pulses afterwards.
- R3: A tracked request taken at clock edge t0 and acknowledged at edge t0+k, for any 1 ≤ k ≤ WINDOW, produces no error.
- R4: A tracked request taken at edge t0 that gets neither `ack_i` nor `serr_i` at edges t0+1 to t0+WINDOW sets `err_o` for exactly the one cycle after edge t0+WINDOW. The monitor then returns to idle and reports nothing further for that transfer.
- R5: An acknowledge at edge t0+WINDOW, the last edge of the window, counts as success and produces no error.
- R6: `serr_i` at edge t0+k (1 ≤ k ≤ WINDOW) of a tracked transfer sets `err_o` for the one cycle after that edge and ends the transfer. This also holds when `ack_i` is high at the same edge.
- R7: `err_fetch_o` is 1 with `err_o` when the failing transfer was requested with `fetch_i`=1 (instruction fetch). It is 0 with `err_o` for a data access (`fetch_i`=0). `err_fetch_o` is 0 whenever `err_o` is 0.
- R8: A new tracked request while a transfer is pending restarts the window and takes the new access type. An acknowledge, slave error or expiry at that same edge still applies to the old transfer, with the old type.
- R9: An acknowledge in the same cycle as its request is not counted. Monitoring starts at the edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle pulse starting a transfer |
| ack_i | input | 1 | Slave acknowledge |
| serr_i | input | 1 | Slave error response |
| fetch_i | input | 1 | Access type with `req_i`: 1 = instruction fetch, 0 = data access |
| ext_i | input | 1 | With `req_i`: 1 = transfer goes to the external memory region |
| err_o | output | 1 | One-cycle bus error pulse |
| err_fetch_o | output | 1 | Error type with `err_o`: 1 = fetch error, 0 = data error |

## Verification
A stuck or miscounted window counter shows up as an error pulse one edge too early or too late relative to WINDOW. It can also show up as a missing pulse, or as a second pulse. The directed tests sample `err_o` at every edge from t0+1 to t0+WINDOW+1, so an off-by-one is seen within the same transfer. A wrong stored access type appears in `err_fetch_o` in the very cycle of the pulse. A state bit that fails to clear after completion gives a spurious error within WINDOW cycles, which the idle checks after each scenario would catch.

// File: rtl/bto_pkg.sv
package bto_pkg;
   typedef enum logic {
      KIND_DATA  = 1'b0,
      KIND_FETCH = 1'b1
   } xfer_kind_e;
endpackage

// File: rtl/bto_window_cnt.sv
// Cycle counter for the response window. It raises last_o on the final edge
// at which the pending transfer may still complete.
module bto_window_cnt #(
   parameter int WINDOW     = 15,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic run_i,
   output logic last_o
);
   localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(WINDOW - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (COUNT_DOWN) begin : g_down
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (load_i) begin
               cnt_q <= TERM;
            end else if (run_i && (cnt_q != '0)) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign last_o = (cnt_q == '0);
      end else begin : g_up
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (load_i) begin
               cnt_q <= '0;
            end else if (run_i && (cnt_q != TERM)) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign last_o = (cnt_q == TERM);
      end
   endgenerate
endmodule

// File: rtl/bto_tracker.sv
// Holds whether a transfer is pending and of which type, and decides how it ends.
module bto_tracker
   import bto_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       req_i,
   input  logic       ext_i,
   input  xfer_kind_e kind_i,
   input  logic       ack_i,
   input  logic       serr_i,
   input  logic       last_i,
   output logic       start_o,
   output logic       busy_o,
   output xfer_kind_e kind_o,
   output logic       slv_fail_o,
   output logic       tmo_o
);
   logic       busy_q;
   xfer_kind_e kind_q;
   logic       keep;

   assign start_o    = req_i & ~ext_i;
   assign slv_fail_o = busy_q & serr_i;
   assign tmo_o      = busy_q & ~ack_i & ~serr_i & last_i;
   assign keep       = busy_q & ~ack_i & ~serr_i & ~last_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         kind_q <= KIND_DATA;
      end else begin
         busy_q <= start_o | keep;
         if (start_o) begin
            kind_q <= kind_i;
         end
      end
   end

   assign busy_o = busy_q;
   assign kind_o = kind_q;
endmodule

// File: rtl/bto_err_gen.sv
// Registers the error pulse and its type toward the CPU.
module bto_err_gen
   import bto_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       slv_fail_i,
   input  logic       tmo_i,
   input  xfer_kind_e kind_i,
   output logic       err_o,
   output logic       err_fetch_o
);
   logic fail;

   assign fail = slv_fail_i | tmo_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_o       <= 1'b0;
         err_fetch_o <= 1'b0;
      end else begin
         err_o       <= fail;
         err_fetch_o <= fail & (kind_i == KIND_FETCH);
      end
   end
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
   import bto_pkg::*;
#(
   parameter int WINDOW     = 15,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic ack_i,
   input  logic serr_i,
   input  logic fetch_i,
   input  logic ext_i,
   output logic err_o,
   output logic err_fetch_o
);
   generate
      if (WINDOW < 2) begin : g_bad_window
         $error("bus_timeout_mon: WINDOW must be at least 2");
      end
   endgenerate

   logic       trk_start;
   logic       trk_busy;
   logic       trk_last;
   logic       trk_slv_fail;
   logic       trk_tmo;
   xfer_kind_e trk_kind;
   xfer_kind_e req_kind;

   assign req_kind = fetch_i ? KIND_FETCH : KIND_DATA;

   bto_tracker u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i),
      .ext_i      (ext_i),
      .kind_i     (req_kind),
      .ack_i      (ack_i),
      .serr_i     (serr_i),
      .last_i     (trk_last),
      .start_o    (trk_start),
      .busy_o     (trk_busy),
      .kind_o     (trk_kind),
      .slv_fail_o (trk_slv_fail),
      .tmo_o      (trk_tmo)
   );

   bto_window_cnt #(
      .WINDOW     (WINDOW),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (trk_start),
      .run_i  (trk_busy),
      .last_o (trk_last)
   );

   bto_err_gen u_err (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .slv_fail_i  (trk_slv_fail),
      .tmo_i       (trk_tmo),
      .kind_i      (trk_kind),
      .err_o       (err_o),
      .err_fetch_o (err_fetch_o)
   );
endmodule

// File: rtl/bto_checker.sv
module bto_checker #(
   parameter int WINDOW = 15
) (
   input logic clk_i,
   input logic rst_ni,
   input logic req_i,
   input logic ack_i,
   input logic serr_i,
   input logic ext_i,
   input logic busy,
   input logic err_o,
   input logic err_fetch_o
);
   localparam int AGE_W = $clog2(WINDOW + 2) + 1;
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   // Edges since the latest tracked request, saturating.
   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         age_q <= '0;
      end else if (req_i && !ext_i) begin
         age_q <= '0;
      end else if (age_q != AGE_MAX) begin
         age_q <= age_q + 1'b1;
      end
   end

   assert_ext_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy && req_i && ext_i) |=> !err_o);

   assert_type_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_fetch_o |-> err_o);

   assert_window_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |-> (age_q <= AGE_W'(WINDOW - 1)));

   assert_ack_clean_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && ack_i && !serr_i) |=> !err_o);

   assert_slave_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && serr_i) |=> err_o);

   assert_err_needs_track_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> $past(busy));
endmodule

bind bus_timeout_mon bto_checker #(.WINDOW(WINDOW)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_i       (req_i),
   .ack_i       (ack_i),
   .serr_i      (serr_i),
   .ext_i       (ext_i),
   .busy        (trk_busy),
   .err_o       (err_o),
   .err_fetch_o (err_fetch_o)
);

// File: tb/sim_bus_timeout_mon.sv
`timescale 1ns/1ps
module sim_bus_timeout_mon;
   localparam int W = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, ack = 1'b0, serr = 1'b0, fetch = 1'b0, ext = 1'b0;
   logic err, err_fetch;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bus_timeout_mon #(.WINDOW(W)) u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req),
      .ack_i       (ack),
      .serr_i      (serr),
      .fetch_i     (fetch),
      .ext_i       (ext),
      .err_o       (err),
      .err_fetch_o (err_fetch)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // Issue a request; returns just after the edge that takes it (t0).
   task automatic start_req(input logic f, input logic x);
      req = 1'b1; fetch = f; ext = x;
      cyc();
      req = 1'b0; fetch = 1'b0; ext = 1'b0;
   endtask

   task automatic quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         cyc();
         chk(tag, err, 1'b0);
         chk(tag, err_fetch, 1'b0);
      end
   endtask

   // From just after t0: expect pulse exactly after edge t0+W.
   task automatic expect_timeout(input logic exp_f, input string tag);
      for (int i = 1; i < W; i++) begin
         cyc();
         chk({tag, " early"}, err, 1'b0);
      end
      cyc();
      chk({tag, " pulse"}, err, 1'b1);
      chk({tag, " type"}, err_fetch, exp_f);
      cyc();
      chk({tag, " single"}, err, 1'b0);
      quiet(W + 2, {tag, " idle"});
   endtask

   task automatic ack_at(input int k, input string tag);
      for (int i = 1; i < k; i++) begin
         cyc();
         chk(tag, err, 1'b0);
      end
      ack = 1'b1;
      cyc();
      ack = 1'b0;
      chk(tag, err, 1'b0);
      quiet(W + 3, tag);
   endtask

   task automatic t_reset();
      chk("R1 reset err", err, 1'b0);
      chk("R1 reset type", err_fetch, 1'b0);
      quiet(W + 4, "R1 no request");
   endtask

   task automatic t_ack();
      start_req(1'b0, 1'b0);
      ack_at(3, "R3 ack k=3");
      start_req(1'b1, 1'b0);
      ack_at(1, "R3 ack k=1");
      start_req(1'b1, 1'b0);
      ack_at(W, "R5 ack on last edge");
   endtask

   task automatic t_timeout();
      start_req(1'b1, 1'b0);
      expect_timeout(1'b1, "R4 R7 fetch timeout");
      start_req(1'b0, 1'b0);
      expect_timeout(1'b0, "R4 R7 data timeout");
   endtask

   task automatic t_slave_err();
      start_req(1'b1, 1'b0);
      for (int i = 1; i < 5; i++) begin
         cyc();
         chk("R6 before serr", err, 1'b0);
      end
      serr = 1'b1;
      cyc();
      serr = 1'b0;
      chk("R6 serr pulse", err, 1'b1);
      chk("R7 serr fetch type", err_fetch, 1'b1);
      quiet(W + 3, "R6 ends transfer");
      start_req(1'b0, 1'b0);
      cyc();
      serr = 1'b1; ack = 1'b1;
      cyc();
      serr = 1'b0; ack = 1'b0;
      chk("R6 serr with ack", err, 1'b1);
      chk("R7 serr data type", err_fetch, 1'b0);
      quiet(W + 3, "R6 after serr with ack");
   endtask

   task automatic t_external();
      start_req(1'b1, 1'b1);
      quiet(3, "R2 external no ack");
      serr = 1'b1;
      cyc();
      serr = 1'b0;
      chk("R2 external serr", err, 1'b0);
      quiet(W + 3, "R2 external idle");
   endtask

   task automatic t_restart();
      start_req(1'b1, 1'b0);
      for (int i = 0; i < 10; i++) begin
         cyc();
         chk("R8 first window", err, 1'b0);
      end
      start_req(1'b0, 1'b0);
      expect_timeout(1'b0, "R8 restarted window");
      start_req(1'b1, 1'b0);
      cyc(); cyc();
      req = 1'b1; fetch = 1'b0; serr = 1'b1;
      cyc();
      req = 1'b0; serr = 1'b0;
      chk("R8 old transfer error", err, 1'b1);
      chk("R8 old transfer type", err_fetch, 1'b1);
      expect_timeout(1'b0, "R8 new transfer after serr");
   endtask

   task automatic t_same_cycle_ack();
      req = 1'b1; ack = 1'b1; fetch = 1'b0;
      cyc();
      req = 1'b0; ack = 1'b0;
      expect_timeout(1'b0, "R9 same-cycle ack ignored");
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_ack();
      t_timeout();
      t_slave_err();
      t_external();
      t_restart();
      t_same_cycle_ack();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule